// File: doc/BRIEF.md
# Flash Directory Name Lookup

This block looks up a file by name in a fixed directory area of flash. The directory is a packed array of 32-byte records starting at a fixed base address. In each record, the first 24 bytes hold the file name, padded with zero bytes. Offsets 24 to 26 hold the file's flash location and offsets 27 to 29 hold its RAM load address. Both addresses are stored least significant byte first. The last two bytes of a record are never read.

A client places the wanted name on a 192-bit input and pulses `start`. The block then walks the records in order through a byte-wide read port with a valid/ready handshake. In each record it stops comparing at the first byte that differs. The search ends in one of three ways:
- a full 24-byte match, which reports found along with both addresses;
- a record whose first byte is zero, which reports not-found;
- the last record of the area, which reports not-found.

Results and flags stay unchanged until the next accepted start.

Top module: `flash_dir_scan`

## Requirements
- R1: After reset, `busy`, `found`, `not_found` and `rd_valid` are low, and `file_loc` and `load_addr` are zero.
- R2: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` stays unchanged. `rd_data` is taken in the cycle where both are high.
- R3: Byte j of record k is read from address `DIR_BASE + 32*k + j`. The first read of a search is at `DIR_BASE`, and reads never leave the area of `DIR_ENTRIES` records.
- R4: A record matches only when all 24 name bytes equal the requested name. Requested name byte i sits on `req_name[8*i+7:8*i]`, and zero padding bytes are compared like any other byte. A match sets `found`.
- R5: On a match, `file_loc` is {byte 26, byte 25, byte 24} and `load_addr` is {byte 29, byte 28, byte 27} of that record. For example, bytes 00 00 10 01 08 00 at offsets 24..29 give 0x100000 and 0x000801. A record costs exactly 30 reads when it matches.
- R6: Comparison of a record stops at its first differing name byte, and the scan moves to byte 0 of the next record. A record whose first m bytes match costs m+1 reads.
- R7: When byte 0 of a record is 0x00, the search ends with `not_found` after that single read, and no later record is read.
- R8: When none of the `DIR_ENTRIES` records matches and none is a terminator, `not_found` is reported after the last record.
- R9: An accepted `start` clears both flags and both addresses and raises `busy` in the next cycle. A `start` while `busy` is ignored. While idle, the results and flags hold steady whatever `req_name` does, and `found` and `not_found` are never high together or while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a lookup (ignored while busy) |
| req_name | input | 192 | Requested name, byte i at bits 8i+7..8i |
| rd_valid | output | 1 | Read request to the directory |
| rd_addr | output | 24 | Byte address of the request |
| rd_ready | input | 1 | Read completes this cycle, rd_data valid |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Lookup in progress |
| found | output | 1 | Last lookup hit a record |
| not_found | output | 1 | Last lookup missed |
| file_loc | output | 24 | Flash location of the hit |
| load_addr | output | 24 | Load address of the hit |

## Verification
The assertions assume a reader that eventually raises `rd_ready`, and a `req_name` that is held steady while `busy`. The stimulus changes the name only between lookups, and the stalling reader raises ready on a pseudo-random half of its cycles. The bench also tests the idle hold rule by changing `req_name` after a lookup has finished. It checks the terminator, abort and area-end cases with a small area of eight records, so that the whole table and every target can be swept.

// File: rtl/fds_pkg.sv
package fds_pkg;
  localparam int NAME_BYTES = 24;
  localparam int OFS_W      = 5;
  localparam int LOC_FIRST  = 24;
  localparam int LOAD_FIRST = 27;
  localparam int LAST_USED  = 29;
  localparam int FIELD_B    = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/fds_rst_sync.sv
module fds_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/fds_cursor.sv
module fds_cursor #(
  parameter int DIR_ENTRIES = 512,
  localparam int IDX_W = $clog2(DIR_ENTRIES),
  localparam int OFS_W = fds_pkg::OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv_byte,
  input  logic             adv_entry,
  output logic [IDX_W-1:0] entry_idx,
  output logic [OFS_W-1:0] byte_ofs,
  output logic             last_entry
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             en;

  always_comb begin
    idx_d = idx_q;
    ofs_d = ofs_q;
    en    = clear | adv_byte | adv_entry;
    if (clear) begin
      idx_d = '0;
      ofs_d = '0;
    end else if (adv_entry) begin
      idx_d = idx_q + 1'b1;
      ofs_d = '0;
    end else if (adv_byte) begin
      ofs_d = ofs_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ofs_q <= '0;
    end else if (en) begin
      idx_q <= idx_d;
      ofs_q <= ofs_d;
    end
  end

  assign entry_idx  = idx_q;
  assign byte_ofs   = ofs_q;
  assign last_entry = (idx_q == IDX_W'(DIR_ENTRIES - 1));

  p_ofs_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_q <= OFS_W'(fds_pkg::LAST_USED));

  p_entry_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_entry && !clear) |=> (ofs_q == '0));
endmodule

// File: rtl/fds_field_capture.sv
module fds_field_capture #(
  parameter int ADDR_W = 24,
  localparam int OFS_W = fds_pkg::OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [OFS_W-1:0]  byte_ofs,
  input  logic [7:0]        data,
  output logic [ADDR_W-1:0] loc,
  output logic [ADDR_W-1:0] load
);
  logic [ADDR_W-1:0] loc_q, loc_d, load_q, load_d;
  logic              en;

  always_comb begin
    loc_d  = loc_q;
    load_d = load_q;
    en     = clear | capture;
    if (clear) begin
      loc_d  = '0;
      load_d = '0;
    end else if (capture) begin
      for (int k = 0; k < fds_pkg::FIELD_B; k++) begin
        if (byte_ofs == OFS_W'(fds_pkg::LOC_FIRST + k))  loc_d[8*k +: 8]  = data;
        if (byte_ofs == OFS_W'(fds_pkg::LOAD_FIRST + k)) load_d[8*k +: 8] = data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q  <= '0;
      load_q <= '0;
    end else if (en) begin
      loc_q  <= loc_d;
      load_q <= load_d;
    end
  end

  assign loc  = loc_q;
  assign load = load_q;

  p_capture_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (byte_ofs >= OFS_W'(fds_pkg::LOC_FIRST)));
endmodule

// File: rtl/flash_dir_scan.sv
module flash_dir_scan #(
  parameter int          ADDR_W      = 24,
  parameter int          DIR_ENTRIES = 512,
  parameter logic [23:0] DIR_BASE    = 24'h010000,
  localparam int NAME_W = fds_pkg::NAME_BYTES * 8,
  localparam int IDX_W  = $clog2(DIR_ENTRIES),
  localparam int OFS_W  = fds_pkg::OFS_W,
  localparam int AREA_B = DIR_ENTRIES * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NAME_W-1:0] req_name,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic              found,
  output logic              not_found,
  output logic [ADDR_W-1:0] file_loc,
  output logic [ADDR_W-1:0] load_addr
);
  import fds_pkg::*;

  logic             rst_s;
  scan_state_t      st_q, st_d;
  logic             found_q, found_d, miss_q, miss_d;
  logic             cur_clear, adv_byte, adv_entry, capture, res_clear;
  logic [IDX_W-1:0] entry_idx;
  logic [OFS_W-1:0] byte_ofs;
  logic             last_entry;
  logic [7:0]       want_byte;
  logic             in_name, take;

  fds_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  fds_cursor #(.DIR_ENTRIES(DIR_ENTRIES)) u_cursor (
    .clk(clk), .rst_n(rst_s), .clear(cur_clear), .adv_byte(adv_byte),
    .adv_entry(adv_entry), .entry_idx(entry_idx), .byte_ofs(byte_ofs),
    .last_entry(last_entry)
  );

  fds_field_capture #(.ADDR_W(ADDR_W)) u_fields (
    .clk(clk), .rst_n(rst_s), .clear(res_clear), .capture(capture),
    .byte_ofs(byte_ofs), .data(rd_data), .loc(file_loc), .load(load_addr)
  );

  assign in_name = (byte_ofs < OFS_W'(NAME_BYTES));
  assign take    = (st_q == ST_SCAN) && rd_ready;

  always_comb begin
    want_byte = '0;
    for (int i = 0; i < NAME_BYTES; i++)
      if (byte_ofs == OFS_W'(i)) want_byte = req_name[8*i +: 8];
  end

  always_comb begin
    st_d      = st_q;
    found_d   = found_q;
    miss_d    = miss_q;
    cur_clear = 1'b0;
    adv_byte  = 1'b0;
    adv_entry = 1'b0;
    capture   = 1'b0;
    res_clear = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d      = ST_SCAN;
          cur_clear = 1'b1;
          res_clear = 1'b1;
          found_d   = 1'b0;
          miss_d    = 1'b0;
        end
      end
      ST_SCAN: begin
        if (take) begin
          if (in_name) begin
            if (byte_ofs == '0 && rd_data == 8'h00) begin
              miss_d = 1'b1;
              st_d   = ST_IDLE;
            end else if (rd_data != want_byte) begin
              if (last_entry) begin
                miss_d = 1'b1;
                st_d   = ST_IDLE;
              end else begin
                adv_entry = 1'b1;
              end
            end else begin
              adv_byte = 1'b1;
            end
          end else begin
            capture = 1'b1;
            if (byte_ofs == OFS_W'(LAST_USED)) begin
              found_d = 1'b1;
              st_d    = ST_IDLE;
            end else begin
              adv_byte = 1'b1;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      found_q <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      found_q <= found_d;
      miss_q  <= miss_d;
    end
  end

  assign busy      = (st_q == ST_SCAN);
  assign rd_valid  = busy;
  assign rd_addr   = DIR_BASE + ADDR_W'({entry_idx, byte_ofs});
  assign found     = found_q;
  assign not_found = miss_q;

  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  p_in_area_r3: assert property (@(posedge clk) disable iff (!rst_s)
    rd_valid |-> ((rd_addr >= DIR_BASE) &&
                  ({1'b0, rd_addr} < ({1'b0, DIR_BASE} + (ADDR_W+1)'(AREA_B)))));

  p_terminator_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (take && byte_ofs == '0 && rd_data == 8'h00) |=> (not_found && !busy));

  p_excl_flags_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !(found && not_found) && !(busy && (found || not_found)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (!busy && !start) |=> ($stable(found) && $stable(not_found) &&
                           $stable(file_loc) && $stable(load_addr)));
endmodule

// File: tb/flash_dir_scan_bench.sv
module flash_dir_scan_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          NENT       = 8;
  localparam logic [23:0] BASE       = 24'h010000;
  localparam int          MEMB       = NENT * 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [191:0] req_name = '0;
  logic         rd_valid, rd_ready, busy, found, not_found;
  logic [23:0]  rd_addr, file_loc, load_addr;
  logic [7:0]   rd_data;

  logic [7:0]   mem [MEMB];
  logic         stall_en = 1'b0;
  logic [7:0]   lfsr = 8'h5a;

  int tests = 0, fails = 0, cycles = 0;
  int rd_cnt = 0;
  int exp_n;
  logic [23:0] exp_addr [256];
  logic exp_found;
  logic [23:0] exp_loc, exp_load;
  bit addr_err = 0, stall_err = 0;
  logic pv = 0, pr = 0;
  logic [23:0] pa = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_dir_scan #(.DIR_ENTRIES(NENT), .DIR_BASE(BASE)) u_flash_dir_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .req_name(req_name),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .busy(busy), .found(found), .not_found(not_found),
    .file_loc(file_loc), .load_addr(load_addr)
  );

  assign rd_ready = !stall_en || lfsr[0];
  assign rd_data  = (rd_addr >= BASE && rd_addr < BASE + 24'(MEMB))
                    ? mem[int'(rd_addr - BASE)] : 8'h00;

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (pv && !pr && (!rd_valid || rd_addr != pa)) stall_err = 1;
    if (rd_valid && rd_ready) begin
      if (rd_cnt >= 256 || rd_cnt >= exp_n || rd_addr != exp_addr[rd_cnt]) addr_err = 1;
      rd_cnt = rd_cnt + 1;
    end
    pv <= rd_valid; pr <= rd_ready; pa <= rd_addr;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [191:0] mkname(input string s);
    logic [191:0] n = '0;
    for (int i = 0; i < s.len() && i < 24; i++) n[8*i +: 8] = s[i];
    return n;
  endfunction

  task automatic put_entry(input int e, input logic [191:0] n, input logic [23:0] loc, input logic [23:0] ld);
    for (int j = 0; j < 24; j++) mem[e*32 + j] = n[8*j +: 8];
    for (int k = 0; k < 3; k++) begin
      mem[e*32 + 24 + k] = loc[8*k +: 8];
      mem[e*32 + 27 + k] = ld[8*k +: 8];
    end
    mem[e*32 + 30] = 8'h00;
    mem[e*32 + 31] = 8'h00;
  endtask

  task automatic model(input logic [191:0] n);
    bit done = 0;
    exp_n = 0; exp_found = 0; exp_loc = '0; exp_load = '0;
    for (int e = 0; e < NENT && !done; e++) begin
      bit hit = 1;
      for (int j = 0; j < 24; j++) begin
        exp_addr[exp_n] = BASE + 24'(e*32 + j); exp_n++;
        if (j == 0 && mem[e*32] == 8'h00) begin done = 1; hit = 0; break; end
        if (mem[e*32 + j] != n[8*j +: 8]) begin hit = 0; break; end
      end
      if (hit) begin
        for (int j = 24; j < 30; j++) begin exp_addr[exp_n] = BASE + 24'(e*32 + j); exp_n++; end
        exp_loc  = {mem[e*32+26], mem[e*32+25], mem[e*32+24]};
        exp_load = {mem[e*32+29], mem[e*32+28], mem[e*32+27]};
        exp_found = 1; done = 1;
      end
    end
  endtask

  task automatic run(input logic [191:0] n, input string tag, input bit poke);
    int guard = 0;
    model(n);
    @(negedge clk);
    req_name = n; rd_cnt = 0; addr_err = 0; stall_err = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy && !found && !not_found && file_loc == 0, "R9 start clears", {busy, found, not_found}, 3'b100);
    while (busy && guard < 5000) begin
      @(negedge clk); guard++;
      if (poke && guard == 4) start = 1;
      else start = 0;
    end
    start = 0;
    check(found == exp_found, {tag, " found"}, found, exp_found);
    check(not_found == !exp_found, {tag, " not_found"}, not_found, !exp_found);
    check(file_loc == exp_loc, "R5 file_loc", file_loc, exp_loc);
    check(load_addr == exp_load, "R5 load_addr", load_addr, exp_load);
    check(rd_cnt == exp_n, "R6 read count", rd_cnt, exp_n);
    check(!addr_err, "R3 address order", addr_err, 0);
    check(!stall_err, "R2 stall hold", stall_err, 0);
  endtask

  function automatic logic [191:0] sweep_name(input int e);
    logic [191:0] n;
    for (int j = 0; j < 24; j++) n[8*j +: 8] = (j < 3*e) ? 8'(8'h41 + j) : 8'(8'h61 + e);
    return n;
  endfunction

  initial begin
    for (int i = 0; i < MEMB; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !found && !not_found && !rd_valid && file_loc == 0 && load_addr == 0,
          "R1 reset state", {busy, found, not_found, rd_valid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!busy && !rd_valid && !found && !not_found, "R1 after release", {busy, rd_valid}, 0);

    put_entry(0, mkname("HELLO"), 24'h100000, 24'h000801);
    put_entry(1, mkname("WORLD"), 24'h123456, 24'h00c000);
    run(mkname("HELLO"), "R4 example", 0);
    check(file_loc == 24'h100000 && load_addr == 24'h000801, "R5 example fields", file_loc, 24'h100000);
    run(mkname("WORLD"), "R4 second", 0);
    run(mkname("HELL"), "R4 padding", 0);
    run(mkname("XYZ"), "R7 terminator", 0);

    for (int s = 0; s < 2; s++) begin
      stall_en = s[0];
      for (int e = 0; e < NENT; e++) put_entry(e, sweep_name(e), 24'(24'h200000 + e*24'h111), 24'(24'h000800 + e*24'h1010));
      for (int t = 0; t < NENT; t++) run(sweep_name(t), "R4 sweep", 0);
      run(sweep_name(NENT), "R8 area end", 0);
      check(not_found, "R8 miss flag", not_found, 1);
      mem[4*32] = 8'h00;
      run(sweep_name(6), "R7 mid terminator", 0);
      run(sweep_name(2), "R6 before terminator", 0);
    end

    stall_en = 0;
    for (int e = 0; e < NENT; e++) put_entry(e, sweep_name(e), 24'(24'h300000 + e), 24'(24'h001000 + e));
    run(sweep_name(7), "R9 start while busy", 1);

    req_name = mkname("OTHER");
    repeat (20) @(negedge clk);
    check(found && !not_found && file_loc == 24'h300007 && load_addr == 24'h001007 && !rd_valid,
          "R9 idle hold", file_loc, 24'h300007);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule